// File: doc/BRIEF.md
# Dual-Mode SPI Boot and Configuration Port

This port brings a block's configuration registers up from a serial EEPROM without outside help, and afterwards hands those registers to an external controller. When the mode input selects stand-alone operation at reset release, the port becomes an SPI master. It lowers its own chip-select, issues a read opcode with a 16-bit start address, clocks in a fixed number of bytes, and writes them through the register-file write port to register indices counting up from zero. It then releases the bus, raises `boot_done`, and stays a slave from then on. In coprocessor mode it goes straight to slave operation.

As a slave it answers frames that an external master clocks in while slave-select is low. Each frame is an opcode byte, then an 8-bit register address, then any number of data bytes, and the address advances after every data byte. A single 8-bit shift register carries the bits in both modes. The slave inputs pass through two-flop synchronizers, so the external SCK must be much slower than the system clock.

The register-file side has no handshake. Writes are single-cycle valid pulses with no ready, so the register file must take every write in the cycle it is offered. Reads are combinational: the port presents `rf_rd_addr` and expects `rf_rd_data` in the same cycle.

Top module: `spi_boot_port`

## Requirements
- R1: While reset is held, `cs_n_o` is 1 and `sck_o`, `boot_done`, `rf_wr_valid` and `miso_oe` are 0.
- R2: In stand-alone mode (`standalone_i`=1 at reset release), the port drives `cs_n_o` low and `sck_oe`/`mosi_oe` high, then sends on `mosi_o`, MSB first, the read opcode 0x03 followed by the 16-bit `BOOT_ADDR` (high byte first). `mosi_o` changes only after falling SCK edges.
- R3: Each master SCK half-period lasts `CLK_DIV` system clocks. SCK idles low, and no rising edge appears while `cs_n_o` is high.
- R4: After the header, the master clocks exactly `BOOT_BYTES` bytes in from `miso_i`, sampled after rising edges, MSB first. Byte k is written to register index k, for k from 0 to `BOOT_BYTES`-1, and nothing else is written.
- R5: After the last boot byte, `cs_n_o` returns high and `boot_done` rises and stays high. The SCK and MOSI drivers stay disabled from then on.
- R6: In coprocessor mode (`standalone_i`=0 at reset release), the port never lowers `cs_n_o` or enables SCK. `boot_done` is high within a few cycles, and slave frames work at once.
- R7: A slave frame of 0x02, address A, then data D0, D1, ... writes Dk to register (A+k) mod 256.
- R8: A slave frame of 0x03, address A returns the contents of registers A, A+1, ... on `miso_o`, MSB first and modulo 256. Each bit is stable across the rising SCK edge that samples it.
- R9: While slave-select is high, `miso_oe` and `miso_o` are 0.
- R10: Each falling edge of slave-select restarts framing at the opcode byte and discards any partial bits from before.
- R11: Slave-select and slave SCK activity during the master boot is ignored. It causes no write and does not disturb the boot.
- R12: A slave opcode other than 0x02 or 0x03 makes the port ignore the rest of the frame, with no register writes.
- R13: `rf_wr_valid` is a single-cycle pulse per byte with no back-pressure; two consecutive cycles never both carry a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standalone_i | input | 1 | 1 selects self-boot from EEPROM, 0 selects coprocessor mode; sampled at reset release |
| sck_o | output | 1 | Master SCK |
| sck_oe | output | 1 | Enable for the SCK driver (master phase only) |
| sck_i | input | 1 | SCK from an external master |
| mosi_o | output | 1 | Master serial data out |
| mosi_oe | output | 1 | Enable for the MOSI driver |
| mosi_i | input | 1 | Slave serial data in |
| miso_i | input | 1 | Master serial data in from the EEPROM |
| miso_o | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Enable for the MISO driver |
| cs_n_o | output | 1 | Master chip-select to the EEPROM, active low |
| ss_n_i | input | 1 | Slave-select, active low |
| rf_wr_valid | output | 1 | Register write strobe, one cycle, no ready |
| rf_wr_addr | output | 8 | Register write index |
| rf_wr_data | output | 8 | Register write byte |
| rf_rd_addr | output | 8 | Register read index |
| rf_rd_data | input | 8 | Register read byte, same cycle |
| boot_done | output | 1 | High once the port operates as a slave |

## Verification
The assertions assume that the external master keeps each SCK level for several system clocks, so that the synchronized edges are spaced far enough apart for a buffer reload to fit between a falling edge and the next rising edge. They also assume that slave-select stays low until half a bit time after the last falling SCK edge of a frame. The stimulus holds every slave SCK level for eight clocks, and keeps a half-bit gap before and after each slave-select change. All inputs are driven on the falling system clock edge. The EEPROM model changes `miso_i` only on falling master SCK edges, which respects the one-cycle sampling offset after a rising edge.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam int         HDR_BYTES = 3;

  typedef enum logic [2:0] {
    PH_INIT, PH_START, PH_MASTER, PH_FINISH, PH_SLAVE
  } phase_e;

  typedef enum logic [1:0] {
    SL_CMD, SL_ADDR, SL_DATA, SL_SKIP
  } sl_state_e;
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[i] <= RST_VAL[i];
        s2_q[i] <= RST_VAL[i];
      end else begin
        s1_q[i] <= d[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/spi_clk_gen.sv
`timescale 1ns/1ps
module spi_clk_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      sck   <= 1'b0;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q <= '0;
      sck   <= ~sck;
      rise  <= ~sck;
      fall  <= sck;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_shift8.sv
`timescale 1ns/1ps
module spi_shift8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       rise,
  input  logic       fall,
  input  logic       din,
  input  logic       wrap_load,
  input  logic [7:0] wrap_val,
  output logic       dout,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic [7:0] sh_q;
  logic [2:0] cnt_q;
  logic       bit_q;

  assign byte_val  = {sh_q[6:0], bit_q};
  assign byte_done = fall && (cnt_q == 3'd7);
  assign dout      = sh_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else if (clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else if (load) begin
      sh_q <= load_val;
    end else begin
      if (rise) bit_q <= din;
      if (fall) begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= (byte_done && wrap_load) ? wrap_val : byte_val;
      end
    end
  end

  // R8: a buffer reload never coincides with an SCK edge
  assert_load_off_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(rise || fall)) else $error("load collided with an SCK edge");
endmodule

// File: rtl/spi_boot_port.sv
`timescale 1ns/1ps
module spi_boot_port
  import spi_port_pkg::*;
#(
  parameter int          BOOT_BYTES = 8,
  parameter int          CLK_DIV    = 2,
  parameter logic [15:0] BOOT_ADDR  = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standalone_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       mosi_i,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  output logic       cs_n_o,
  input  logic       ss_n_i,
  output logic       rf_wr_valid,
  output logic [7:0] rf_wr_addr,
  output logic [7:0] rf_wr_data,
  output logic [7:0] rf_rd_addr,
  input  logic [7:0] rf_rd_data,
  output logic       boot_done
);
  localparam int TOTAL = HDR_BYTES + BOOT_BYTES;
  localparam int CW    = $clog2(TOTAL + 1);

  phase_e    phase_q;
  sl_state_e sl_state_q;
  logic [CW-1:0] mcnt_q;
  logic       coproc_q, cs_n_q, clk_en_q, done_q;
  logic       wr_valid_q;
  logic [7:0] wr_addr_q, wr_data_q, sl_addr_q;
  logic       sl_rd_q, sl_active_q, ld_pend_q;
  logic       sck_d, ss_d;

  // synchronized slave pins
  logic [2:0] sync_q;
  logic       ss_s, sck_s, mosi_s;
  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n_i, sck_i, mosi_i}), .q(sync_q));
  assign ss_s   = sync_q[2];
  assign sck_s  = sync_q[1];
  assign mosi_s = sync_q[0];

  logic s_rise, s_fall, ss_fall, master;
  assign s_rise  = sck_s & ~sck_d;
  assign s_fall  = ~sck_s & sck_d;
  assign ss_fall = ss_d & ~ss_s;
  assign master  = (phase_q == PH_START) || (phase_q == PH_MASTER) ||
                   (phase_q == PH_FINISH);

  // master clock
  logic cg_sck, cg_rise, cg_fall;
  spi_clk_gen #(.DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(clk_en_q),
    .sck(cg_sck), .rise(cg_rise), .fall(cg_fall));

  // shared shift register
  logic       sh_rise, sh_fall, sh_din, sh_clr, sh_load;
  logic [7:0] sh_load_val, sh_wrap_val, sh_byte;
  logic       sh_dout, sh_done;

  assign sh_rise     = master ? cg_rise : (sl_active_q && s_rise);
  assign sh_fall     = master ? cg_fall : (sl_active_q && s_fall);
  assign sh_din      = master ? miso_i : mosi_s;
  assign sh_clr      = (phase_q == PH_SLAVE) && ss_fall;
  assign sh_load     = (phase_q == PH_START) || ld_pend_q;
  assign sh_load_val = (phase_q == PH_START) ? OP_READ : rf_rd_data;

  always_comb begin
    if (mcnt_q == CW'(0))      sh_wrap_val = BOOT_ADDR[15:8];
    else if (mcnt_q == CW'(1)) sh_wrap_val = BOOT_ADDR[7:0];
    else                       sh_wrap_val = 8'h00;
  end

  spi_shift8 u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(sh_load),
    .load_val(sh_load_val), .rise(sh_rise), .fall(sh_fall), .din(sh_din),
    .wrap_load(master), .wrap_val(sh_wrap_val),
    .dout(sh_dout), .byte_done(sh_done), .byte_val(sh_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_INIT;
      coproc_q    <= 1'b0;
      cs_n_q      <= 1'b1;
      clk_en_q    <= 1'b0;
      done_q      <= 1'b0;
      mcnt_q      <= '0;
      wr_valid_q  <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
      sl_state_q  <= SL_CMD;
      sl_rd_q     <= 1'b0;
      sl_addr_q   <= '0;
      sl_active_q <= 1'b0;
      ld_pend_q   <= 1'b0;
      sck_d       <= 1'b0;
      ss_d        <= 1'b1;
    end else begin
      sck_d      <= sck_s;
      ss_d       <= ss_s;
      wr_valid_q <= 1'b0;
      ld_pend_q  <= 1'b0;
      unique case (phase_q)
        PH_INIT: begin
          if (standalone_i) begin
            phase_q <= PH_START;
          end else begin
            coproc_q <= 1'b1;
            done_q   <= 1'b1;
            phase_q  <= PH_SLAVE;
          end
        end
        PH_START: begin
          cs_n_q   <= 1'b0;
          clk_en_q <= 1'b1;
          phase_q  <= PH_MASTER;
        end
        PH_MASTER: begin
          if (sh_done) begin
            mcnt_q <= mcnt_q + 1'b1;
            if (mcnt_q >= CW'(HDR_BYTES)) begin
              wr_valid_q <= 1'b1;
              wr_addr_q  <= 8'(mcnt_q - CW'(HDR_BYTES));
              wr_data_q  <= sh_byte;
            end
            if (mcnt_q == CW'(TOTAL - 1)) begin
              clk_en_q <= 1'b0;
              phase_q  <= PH_FINISH;
            end
          end
        end
        PH_FINISH: begin
          cs_n_q  <= 1'b1;
          done_q  <= 1'b1;
          phase_q <= PH_SLAVE;
        end
        PH_SLAVE: begin
          if (ss_fall) begin
            sl_active_q <= 1'b1;
            sl_state_q  <= SL_CMD;
          end else if (ss_s) begin
            sl_active_q <= 1'b0;
            sl_state_q  <= SL_CMD;
          end else if (sl_active_q && sh_done) begin
            unique case (sl_state_q)
              SL_CMD: begin
                if (sh_byte == OP_WRITE) begin
                  sl_rd_q    <= 1'b0;
                  sl_state_q <= SL_ADDR;
                end else if (sh_byte == OP_READ) begin
                  sl_rd_q    <= 1'b1;
                  sl_state_q <= SL_ADDR;
                end else begin
                  sl_state_q <= SL_SKIP;
                end
              end
              SL_ADDR: begin
                sl_addr_q  <= sh_byte;
                ld_pend_q  <= sl_rd_q;
                sl_state_q <= SL_DATA;
              end
              SL_DATA: begin
                if (!sl_rd_q) begin
                  wr_valid_q <= 1'b1;
                  wr_addr_q  <= sl_addr_q;
                  wr_data_q  <= sh_byte;
                end
                sl_addr_q <= sl_addr_q + 8'd1;
                ld_pend_q <= sl_rd_q;
              end
              default: sl_state_q <= SL_SKIP;
            endcase
          end
        end
        default: phase_q <= PH_INIT;
      endcase
    end
  end

  assign sck_o       = cg_sck;
  assign sck_oe      = master;
  assign mosi_o      = master ? sh_dout : 1'b0;
  assign mosi_oe     = master;
  assign cs_n_o      = cs_n_q;
  assign miso_oe     = (phase_q == PH_SLAVE) && sl_active_q;
  assign miso_o      = (miso_oe && sl_rd_q && sl_state_q == SL_DATA) ? sh_dout : 1'b0;
  assign rf_wr_valid = wr_valid_q;
  assign rf_wr_addr  = wr_addr_q;
  assign rf_wr_data  = wr_data_q;
  assign rf_rd_addr  = sl_addr_q;
  assign boot_done   = done_q;

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done) else $error("boot_done dropped");
  assert_master_off_after_boot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (cs_n_o && !sck_oe && !mosi_oe)) else $error("master active after boot");
  assert_sck_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> !cs_n_o) else $error("SCK rose with chip-select high");
  assert_miso_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_s && $past(ss_s)) |-> (!miso_oe && !miso_o)) else $error("MISO driven while deselected");
  assert_coproc_no_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
    coproc_q |-> (cs_n_o && !sck_oe)) else $error("master activity in coprocessor mode");
  assert_single_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid |=> !rf_wr_valid) else $error("write strobe held two cycles");
endmodule

// File: tb/test_spi_boot_port.sv
`timescale 1ns/1ps
module test_spi_boot_port;
  localparam int  NB   = 6;
  localparam int  DIV  = 3;
  localparam time HALF = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standalone_i = 1'b1;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1, miso_i = 1'b0;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, cs_n_o;
  logic rf_wr_valid, boot_done;
  logic [7:0] rf_wr_addr, rf_wr_data, rf_rd_addr, rf_rd_data;

  always #2 clk = ~clk;

  spi_boot_port #(.BOOT_BYTES(NB), .CLK_DIV(DIV), .BOOT_ADDR(16'h0000)) i_spi_boot_port (
    .clk(clk), .rst_n(rst_n), .standalone_i(standalone_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .cs_n_o(cs_n_o), .ss_n_i(ss_n_i),
    .rf_wr_valid(rf_wr_valid), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data), .boot_done(boot_done));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ee_byte(input int k);
    return 8'(k * 37 + 90) ^ 8'hC3;
  endfunction

  // register file model
  logic [7:0] rf_mem [256];
  int wr_count = 0;
  int dbl_wr   = 0;
  logic prev_valid = 1'b0;
  initial for (int i = 0; i < 256; i++) rf_mem[i] = 8'h00;
  always @(posedge clk) begin
    if (rf_wr_valid) begin
      rf_mem[rf_wr_addr] <= rf_wr_data;
      wr_count++;
      if (prev_valid) dbl_wr++;
    end
    prev_valid <= rf_wr_valid;
  end
  assign rf_rd_data = rf_mem[rf_rd_addr];

  // EEPROM model
  int ee_rises = 0;
  int stray_rises = 0;
  int all_rises = 0;
  logic [23:0] ee_hdr = '0;
  time t_rise = 0;
  time last_half = 0;
  always @(negedge cs_n_o) ee_rises = 0;
  always @(posedge sck_o) begin
    all_rises++;
    t_rise = $time;
    if (cs_n_o) stray_rises++;
    else begin
      if (ee_rises < 24) ee_hdr = {ee_hdr[22:0], mosi_o};
      ee_rises++;
    end
  end
  always @(negedge sck_o) begin
    last_half = $time - t_rise;
    if (!cs_n_o && ee_rises >= 24) begin
      int p;
      logic [7:0] b;
      p = ee_rises - 24;
      b = ee_byte(p / 8);
      miso_i = b[7 - (p % 8)];
    end
  end

  // slave-side helpers
  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = tx[i];
      #HALF;
      sck_i = 1'b1;
      rx[i] = miso_o;
      #HALF;
      sck_i = 1'b0;
    end
  endtask
  task automatic ss_lo();
    ss_n_i = 1'b0;
    #HALF;
  endtask
  task automatic ss_hi();
    #HALF;
    ss_n_i = 1'b1;
    #(4 * HALF);
  endtask
  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] rx;
    ss_lo();
    spi_byte(8'h02, rx); spi_byte(a, rx); spi_byte(d, rx);
    ss_hi();
  endtask
  task automatic rd1(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] rx;
    ss_lo();
    spi_byte(8'h03, rx); spi_byte(a, rx); spi_byte(8'h00, d);
    ss_hi();
  endtask

  // op, address, data written or expected
  localparam logic [23:0] VEC [8] = '{
    {8'h02, 8'h10, 8'h3C}, {8'h02, 8'h11, 8'hC3}, {8'h02, 8'hFF, 8'h81},
    {8'h03, 8'h10, 8'h3C}, {8'h03, 8'h11, 8'hC3}, {8'h03, 8'hFF, 8'h81},
    {8'h02, 8'h10, 8'h00}, {8'h03, 8'h10, 8'h00}
  };

  initial begin : watchdog
    #(100000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    int snap;
    @(negedge clk);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n_o === 1'b1 && sck_o === 1'b0 && boot_done === 1'b0 && rf_wr_valid === 1'b0 && miso_oe === 1'b0,
        "R1 reset idle", {cs_n_o, sck_o, boot_done, rf_wr_valid, miso_oe}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: slave activity during boot
    ss_n_i = 1'b0;
    mosi_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #HALF; sck_i = 1'b1; #HALF; sck_i = 1'b0;
    end
    #HALF; ss_n_i = 1'b1;
    // R2 mid-boot state
    chk(!boot_done && !cs_n_o && sck_oe && mosi_oe, "R2 master active mid-boot",
        {boot_done, cs_n_o, sck_oe, mosi_oe}, 4'b0011);
    for (int i = 0; i < 5000 && !boot_done; i++) @(negedge clk);
    chk(boot_done === 1'b1, "R5 boot_done raised", boot_done, 1);
    chk(ee_hdr == 24'h030000, "R2 header opcode and address", ee_hdr, 24'h030000);
    chk(last_half == time'(DIV * 4), "R3 SCK half-period", 32'(last_half), DIV * 4);
    chk(stray_rises == 0, "R3 no SCK with chip-select high", stray_rises, 0);
    chk(ee_rises == (3 + NB) * 8, "R4 master clock count", ee_rises, (3 + NB) * 8);
    for (int i = 0; i < NB; i++)
      chk(rf_mem[i] == ee_byte(i), "R4 boot byte", rf_mem[i], ee_byte(i));
    chk(rf_mem[NB] == 8'h00, "R4 nothing past last index", rf_mem[NB], 0);
    chk(wr_count == NB, "R11 no writes from ignored slave activity", wr_count, NB);
    chk(cs_n_o && !sck_oe && !mosi_oe, "R5 master released", {cs_n_o, sck_oe, mosi_oe}, 3'b100);
    chk(!miso_oe && !miso_o, "R9 MISO idle while deselected", {miso_oe, miso_o}, 0);

    // table of slave transfers, R7 writes and R8 reads
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][23:16] == 8'h02) wr1(VEC[v][15:8], VEC[v][7:0]);
      else begin
        rd1(VEC[v][15:8], rx);
        chk(rx == VEC[v][7:0], "R8 table read", rx, VEC[v][7:0]);
      end
    end

    // R7 burst write with auto-increment
    ss_lo();
    spi_byte(8'h02, rx); spi_byte(8'h20, rx);
    spi_byte(8'h11, rx); spi_byte(8'h22, rx); spi_byte(8'h33, rx);
    ss_hi();
    chk(rf_mem[8'h20] == 8'h11 && rf_mem[8'h21] == 8'h22 && rf_mem[8'h22] == 8'h33,
        "R7 burst write", {rf_mem[8'h20], rf_mem[8'h21], rf_mem[8'h22]}, 24'h112233);
    // R8 burst read, and R9 oe during a frame
    ss_lo();
    spi_byte(8'h03, rx); spi_byte(8'h1F, rx);
    chk(miso_oe === 1'b1, "R9 MISO enabled when selected", miso_oe, 1);
    spi_byte(8'h00, rx); chk(rx == 8'h00, "R8 burst read 1F", rx, 8'h00);
    spi_byte(8'h00, rx); chk(rx == 8'h11, "R8 burst read 20", rx, 8'h11);
    spi_byte(8'h00, rx); chk(rx == 8'h22, "R8 burst read 21", rx, 8'h22);
    spi_byte(8'h00, rx); chk(rx == 8'h33, "R8 burst read 22", rx, 8'h33);
    ss_hi();
    // R8 address wrap FF -> 00
    ss_lo();
    spi_byte(8'h03, rx); spi_byte(8'hFF, rx);
    spi_byte(8'h00, rx); chk(rx == 8'h81, "R8 read at FF", rx, 8'h81);
    spi_byte(8'h00, rx); chk(rx == ee_byte(0), "R8 wrap to 00", rx, ee_byte(0));
    ss_hi();
    chk(!miso_oe && !miso_o, "R9 MISO idle after frame", {miso_oe, miso_o}, 0);

    // R10 partial bits discarded on reselect
    ss_lo();
    mosi_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #HALF; sck_i = 1'b1; #HALF; sck_i = 1'b0;
    end
    ss_hi();
    snap = wr_count;
    wr1(8'h30, 8'h5A);
    chk(wr_count == snap + 1, "R10 exactly one write after reselect", wr_count, snap + 1);
    rd1(8'h30, rx);
    chk(rx == 8'h5A, "R10 framing restarted", rx, 8'h5A);

    // R12 unknown opcode
    snap = wr_count;
    ss_lo();
    spi_byte(8'h05, rx); spi_byte(8'h30, rx); spi_byte(8'hFF, rx);
    ss_hi();
    chk(wr_count == snap, "R12 no write on unknown opcode", wr_count, snap);
    rd1(8'h30, rx);
    chk(rx == 8'h5A, "R12 register untouched", rx, 8'h5A);
    chk(dbl_wr == 0, "R13 write strobe one cycle", dbl_wr, 0);

    // R6 coprocessor mode
    rst_n = 1'b0;
    standalone_i = 1'b0;
    repeat (4) @(negedge clk);
    snap = all_rises;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(boot_done === 1'b1, "R6 boot_done in coprocessor mode", boot_done, 1);
    chk(cs_n_o && !sck_oe, "R6 no master drive", {cs_n_o, sck_oe}, 2'b10);
    repeat (200) @(negedge clk);
    chk(all_rises == snap && cs_n_o, "R6 no master SCK", all_rises - snap, 0);
    wr1(8'h40, 8'hA7);
    rd1(8'h40, rx);
    chk(rx == 8'hA7, "R6 slave access in coprocessor mode", rx, 8'hA7);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule